// File: doc/BRIEF.md
# SPI Serial EEPROM Command Engine

This block is the slave side of a byte-addressed serial EEPROM on an SPI bus, in clock modes 0 and 3. It holds a 4096-byte array in registers. It decodes a one-byte opcode, and for array reads and writes a two-byte address, shifting everything MSB first. Reads stream bytes from an address pointer that advances after each byte. Writes gather up to one page of bytes into a local buffer. When chip select rises at a clean byte boundary, the buffer is copied into the array and a self-timed busy window starts.

The serial pins are oversampled in the system clock domain through a synchroniser with a configurable number of stages. The busy window is a system-clock counter, so a simulation can shorten it. The write-enable latch and the status byte live in a companion block. This engine reads them as plain inputs and reports the write-enable, write-disable, status-write and commit events to that block as one-cycle pulses.

Top module: `spi_eeprom_engine`

## Requirements
- R1: Bits on `si` are taken on `sck` rising edges and `so` changes after `sck` falling edges. Both clock idle levels work (mode 0 idles low, mode 3 idles high).
- R2: `so_oe` is 0 after reset, whenever `cs_n` is high, and in every phase that is not returning data.
- R3: READ (opcode 0x03) is followed by a 16-bit address whose top 4 bits are ignored. The byte at that address is then returned MSB first, with `so_oe` high.
- R4: During a READ the pointer advances by one after each byte and wraps from 0x0FFF to 0x0000 for as long as `cs_n` stays low.
- R5: WRITE (opcode 0x02) with `wel_i` high stores the data bytes when `cs_n` rises. `commit_o` pulses once, and `wip_o` is then high for exactly `T_WR` system clocks.
- R6: Write data stays inside the 32-byte page chosen by address bits [11:5]. Past offset 31, the in-page offset wraps to 0 and later bytes overwrite earlier ones.
- R7: No commit happens if `cs_n` rises with a partial byte shifted in, or before any data byte has been received.
- R8: A WRITE whose address completes while `wel_i` is low stores nothing and gives no `commit_o`.
- R9: While `wip_o` is high, a READ leaves `so_oe` low, and a WRITE is dropped with no commit.
- R10: `bp_i` locks part of the array: 01 locks the top quarter (address bits [11:10] = 11), 10 locks the top half (bit 11 = 1), 11 locks all of it. A write to a locked page stores nothing and gives no `commit_o`.
- R11: Status read (opcode 0x05) shifts out `stat_i`, reloaded at each byte boundary, for as long as clocks continue.
- R12: Each of these raises its own one-cycle pulse when `cs_n` rises: write enable (0x06) and write disable (0x04), each after exactly 8 bits, and status write (0x01) at a byte boundary after at least one data byte. The status write presents its last data byte on `wrsr_data_o`. Any other bit count gives no pulse.
- R13: Any other opcode makes the rest of the transaction ignored: no pulse, and `so_oe` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock for oversampling and the write timer |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck | input | 1 | Serial clock |
| cs_n | input | 1 | Active-low chip select |
| si | input | 1 | Serial data in |
| so | output | 1 | Serial data out (0 when not enabled) |
| so_oe | output | 1 | Output enable for `so` |
| wel_i | input | 1 | Write-enable latch state from the companion block |
| bp_i | input | 2 | Block lock level |
| stat_i | input | 8 | Status byte returned by status read |
| wip_o | output | 1 | Internal write cycle in progress |
| commit_o | output | 1 | Pulse: page write started |
| wren_o | output | 1 | Pulse: write-enable command completed |
| wrdi_o | output | 1 | Pulse: write-disable command completed |
| wrsr_o | output | 1 | Pulse: status write completed |
| wrsr_data_o | output | 8 | Last byte of the status write |

## Verification
Several rules are checked on every cycle. The output enable stays low while chip select is high. Every busy window opens with a commit pulse, never while a previous window is open, and lasts exactly the configured count. At most one event pulse fires at a time, each lasts a single cycle, and a commit requires chip select high and the write-enable input set. Only the directed scenarios can show data behaviour: bytes landing at the right addresses, pointer wrap across the array, in-page overwrite, abandoned and locked writes leaving the array untouched, and reads blocked during a busy window.

// File: rtl/spi_ee_pkg.sv
package spi_ee_pkg;

   localparam logic [7:0] OPC_WRSR = 8'h01;
   localparam logic [7:0] OPC_WRITE = 8'h02;
   localparam logic [7:0] OPC_READ = 8'h03;
   localparam logic [7:0] OPC_WRDI = 8'h04;
   localparam logic [7:0] OPC_RDSR = 8'h05;
   localparam logic [7:0] OPC_WREN = 8'h06;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_OPC,
      ST_ADDR,
      ST_WDATA,
      ST_RDATA,
      ST_STAT,
      ST_SWR,
      ST_CMD,
      ST_SKIP
   } ee_state_t;

   function automatic logic page_locked(input logic [1:0] lvl, input logic [1:0] top);
      case (lvl)
         2'b00:   page_locked = 1'b0;
         2'b01:   page_locked = (top == 2'b11);
         2'b10:   page_locked = top[1];
         default: page_locked = 1'b1;
      endcase
   endfunction

endpackage

// File: rtl/ee_pin_sync.sv
module ee_pin_sync #(
   parameter int W = 1,
   parameter int STAGES = 2,
   parameter logic [W-1:0] RST = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("ee_pin_sync needs at least two stages");
   end

   for (genvar k = 0; k < STAGES; k++) begin : g_st
      logic [W-1:0] r;
      if (k == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) r <= RST;
            else        r <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) r <= RST;
            else        r <= g_st[k-1].r;
         end
      end
   end

   assign q = g_st[STAGES-1].r;

endmodule

// File: rtl/ee_wr_timer.sv
module ee_wr_timer #(
   parameter int T_WR = 1000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy
);

   localparam int CW = (T_WR > 1) ? $clog2(T_WR) : 1;
   localparam logic [CW-1:0] LOAD = CW'(T_WR - 1);
   localparam logic [CW-1:0] ONE = {{(CW-1){1'b0}}, 1'b1};

   if (T_WR < 1) begin : g_bad_time
      $error("ee_wr_timer needs T_WR >= 1");
   end

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
         cnt  <= '0;
      end else if (start && !busy) begin
         busy <= 1'b1;
         cnt  <= LOAD;
      end else if (busy) begin
         if (cnt == '0) busy <= 1'b0;
         else           cnt  <= cnt - ONE;
      end
   end

endmodule

// File: rtl/ee_page_buf.sv
module ee_page_buf #(
   parameter int PAGE_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              we,
   input  logic [PAGE_W-1:0] off,
   input  logic [7:0]        din,
   output logic [7:0]        data [1<<PAGE_W],
   output logic [(1<<PAGE_W)-1:0] mask
);

   localparam int NB = 1 << PAGE_W;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask <= '0;
         for (int i = 0; i < NB; i++) data[i] <= '0;
      end else if (clr) begin
         mask <= '0;
      end else if (we) begin
         for (int i = 0; i < NB; i++) begin
            if (off == PAGE_W'(i)) begin
               data[i] <= din;
               mask[i] <= 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/spi_eeprom_engine.sv
module spi_eeprom_engine
   import spi_ee_pkg::*;
#(
   parameter int ADDR_W = 12,
   parameter int PAGE_W = 5,
   parameter int T_WR = 1_000_000,
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sck,
   input  logic       cs_n,
   input  logic       si,
   output logic       so,
   output logic       so_oe,
   input  logic       wel_i,
   input  logic [1:0] bp_i,
   input  logic [7:0] stat_i,
   output logic       wip_o,
   output logic       commit_o,
   output logic       wren_o,
   output logic       wrdi_o,
   output logic       wrsr_o,
   output logic [7:0] wrsr_data_o
);

   localparam int DEPTH = 1 << ADDR_W;
   localparam int NB = 1 << PAGE_W;
   localparam int PG_W = ADDR_W - PAGE_W;
   localparam int HI_W = ADDR_W - 8;
   localparam logic [ADDR_W-1:0] A_ONE = {{(ADDR_W-1){1'b0}}, 1'b1};
   localparam logic [PAGE_W-1:0] O_ONE = {{(PAGE_W-1){1'b0}}, 1'b1};

   if (ADDR_W < 9 || ADDR_W > 16) begin : g_bad_addr
      $error("ADDR_W must lie in 9..16");
   end
   if (PAGE_W < 1 || PG_W < 2) begin : g_bad_page
      $error("PAGE_W must leave at least two page-number bits");
   end

   // pin oversampling
   logic [2:0] pins_s;
   logic       cs_s, sck_s, si_s, cs_d, sck_d;

   ee_pin_sync #(.W(3), .STAGES(SYNC_STAGES), .RST(3'b100)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({cs_n, sck, si}),
      .q     (pins_s)
   );
   assign {cs_s, sck_s, si_s} = pins_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cs_d  <= 1'b1;
         sck_d <= 1'b0;
      end else begin
         cs_d  <= cs_s;
         sck_d <= sck_s;
      end
   end

   logic cs_fall, cs_rise, sck_rise, sck_fall;
   assign cs_fall  = !cs_s && cs_d;
   assign cs_rise  = cs_s && !cs_d;
   assign sck_rise = !cs_s && !cs_d && sck_s && !sck_d;
   assign sck_fall = !cs_s && !cs_d && !sck_s && sck_d;

   // engine state
   ee_state_t         st;
   logic [2:0]        bcnt;
   logic [6:0]        sr;
   logic [HI_W-1:0]   hi_q;
   logic              ahi_done;
   logic              is_wr;
   logic [ADDR_W-1:0] ptr;
   logic [PAGE_W-1:0] off_q;
   logic [PG_W-1:0]   page_q;
   logic              have;
   logic              cmd_set;
   logic [7:0]        txsr;
   logic              so_q, txon;
   logic [7:0]        swr_q;
   logic              swr_got;
   logic              wip;

   logic [7:0]        mem [DEPTH];
   logic [7:0]        pbuf [NB];
   logic [NB-1:0]     pmask;

   logic              byte_done;
   logic [7:0]        nbyte;
   logic [ADDR_W-1:0] a_full;
   assign byte_done = sck_rise && (bcnt == 3'd7);
   assign nbyte     = {sr, si_s};
   assign a_full    = {hi_q, nbyte};

   logic commit_go, wren_go, wrdi_go, swr_go;
   assign commit_go = cs_rise && (st == ST_WDATA) && (bcnt == 3'd0) && have && !wip
                      && !page_locked(bp_i, page_q[PG_W-1 -: 2]);
   assign wren_go   = cs_rise && (st == ST_CMD) && (bcnt == 3'd0) && cmd_set;
   assign wrdi_go   = cs_rise && (st == ST_CMD) && (bcnt == 3'd0) && !cmd_set;
   assign swr_go    = cs_rise && (st == ST_SWR) && (bcnt == 3'd0) && swr_got;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= ST_IDLE;
         bcnt     <= '0;
         sr       <= '0;
         hi_q     <= '0;
         ahi_done <= 1'b0;
         is_wr    <= 1'b0;
         ptr      <= '0;
         off_q    <= '0;
         page_q   <= '0;
         have     <= 1'b0;
         cmd_set  <= 1'b0;
         txsr     <= '0;
         so_q     <= 1'b0;
         txon     <= 1'b0;
         swr_q    <= '0;
         swr_got  <= 1'b0;
      end else if (cs_fall) begin
         st      <= ST_OPC;
         bcnt    <= '0;
         txon    <= 1'b0;
         have    <= 1'b0;
         swr_got <= 1'b0;
      end else if (cs_rise) begin
         st   <= ST_IDLE;
         txon <= 1'b0;
      end else if (sck_rise && st != ST_IDLE) begin
         sr   <= nbyte[6:0];
         bcnt <= bcnt + 3'd1;
         if (st == ST_CMD) begin
            st <= ST_SKIP;
         end else if (byte_done) begin
            case (st)
               ST_OPC: begin
                  case (nbyte)
                     OPC_READ, OPC_WRITE: begin
                        st       <= ST_ADDR;
                        ahi_done <= 1'b0;
                        is_wr    <= (nbyte == OPC_WRITE);
                     end
                     OPC_RDSR: begin
                        st   <= ST_STAT;
                        txsr <= stat_i;
                     end
                     OPC_WRSR: st <= ST_SWR;
                     OPC_WREN: begin
                        st      <= ST_CMD;
                        cmd_set <= 1'b1;
                     end
                     OPC_WRDI: begin
                        st      <= ST_CMD;
                        cmd_set <= 1'b0;
                     end
                     default:  st <= ST_SKIP;
                  endcase
               end
               ST_ADDR: begin
                  if (!ahi_done) begin
                     hi_q     <= nbyte[HI_W-1:0];
                     ahi_done <= 1'b1;
                  end else if (is_wr) begin
                     if (wel_i && !wip) begin
                        st     <= ST_WDATA;
                        off_q  <= a_full[PAGE_W-1:0];
                        page_q <= a_full[ADDR_W-1:PAGE_W];
                     end else begin
                        st <= ST_SKIP;
                     end
                  end else if (wip) begin
                     st <= ST_SKIP;
                  end else begin
                     st   <= ST_RDATA;
                     txsr <= mem[a_full];
                     ptr  <= a_full + A_ONE;
                  end
               end
               ST_WDATA: begin
                  off_q <= off_q + O_ONE;
                  have  <= 1'b1;
               end
               ST_RDATA: begin
                  txsr <= mem[ptr];
                  ptr  <= ptr + A_ONE;
               end
               ST_STAT: txsr <= stat_i;
               ST_SWR: begin
                  swr_q   <= nbyte;
                  swr_got <= 1'b1;
               end
               default: ;
            endcase
         end
      end else if (sck_fall && (st == ST_RDATA || st == ST_STAT)) begin
         so_q <= txsr[7];
         txsr <= {txsr[6:0], 1'b0};
         txon <= 1'b1;
      end
   end

   ee_page_buf #(.PAGE_W(PAGE_W)) u_pbuf (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (cs_fall),
      .we    (byte_done && st == ST_WDATA && !cs_rise && !cs_fall),
      .off   (off_q),
      .din   (nbyte),
      .data  (pbuf),
      .mask  (pmask)
   );

   always_ff @(posedge clk) begin
      if (commit_go) begin
         for (int i = 0; i < NB; i++) begin
            if (pmask[i]) mem[{page_q, PAGE_W'(i)}] <= pbuf[i];
         end
      end
   end

   ee_wr_timer #(.T_WR(T_WR)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .start (commit_go),
      .busy  (wip)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         commit_o <= 1'b0;
         wren_o   <= 1'b0;
         wrdi_o   <= 1'b0;
         wrsr_o   <= 1'b0;
      end else begin
         commit_o <= commit_go;
         wren_o   <= wren_go;
         wrdi_o   <= wrdi_go;
         wrsr_o   <= swr_go;
      end
   end

   assign wrsr_data_o = swr_q;
   assign wip_o       = wip;
   assign so_oe       = txon && !cs_s;
   assign so          = so_oe & so_q;

endmodule

// File: rtl/spi_eeprom_engine_chk.sv
module spi_eeprom_engine_chk #(
   parameter int T_WR = 1000
) (
   input logic clk,
   input logic rst_n,
   input logic cs_n,
   input logic so_oe,
   input logic wel_i,
   input logic wip_o,
   input logic commit_o,
   input logic wren_o,
   input logic wrdi_o,
   input logic wrsr_o
);

   logic [31:0] busy_len;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     busy_len <= '0;
      else if (wip_o) busy_len <= busy_len + 32'd1;
      else            busy_len <= '0;
   end

   p_hiz_deselect_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n && $past(cs_n) && $past(cs_n, 2) && $past(cs_n, 3) |-> !so_oe);

   p_commit_opens_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
      commit_o |-> wip_o);

   p_busy_needs_commit_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wip_o) |-> commit_o);

   p_busy_length_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(wip_o) |-> (busy_len == 32'(T_WR)));

   p_commit_after_deselect_r7: assert property (@(posedge clk) disable iff (!rst_n)
      commit_o |-> cs_n);

   p_commit_needs_wel_r8: assert property (@(posedge clk) disable iff (!rst_n)
      commit_o |-> wel_i);

   p_no_commit_while_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
      commit_o |-> !$past(wip_o));

   p_events_exclusive_r12: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({wren_o, wrdi_o, wrsr_o, commit_o}));

   p_wren_single_r12: assert property (@(posedge clk) disable iff (!rst_n)
      wren_o |=> !wren_o);

   p_wrsr_single_r12: assert property (@(posedge clk) disable iff (!rst_n)
      wrsr_o |=> !wrsr_o);

endmodule

bind spi_eeprom_engine spi_eeprom_engine_chk #(.T_WR(T_WR)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .cs_n     (cs_n),
   .so_oe    (so_oe),
   .wel_i    (wel_i),
   .wip_o    (wip_o),
   .commit_o (commit_o),
   .wren_o   (wren_o),
   .wrdi_o   (wrdi_o),
   .wrsr_o   (wrsr_o)
);

// File: tb/spi_eeprom_engine_tb.sv
`timescale 1ns/1ps
module spi_eeprom_engine_tb;

   localparam int TW = 2000;
   localparam int HALF = 8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sck = 1'b0;
   logic       cs_n = 1'b1;
   logic       si = 1'b0;
   logic       wel = 1'b0;
   logic [1:0] bp = 2'b00;
   logic [7:0] stat = 8'h00;
   logic       so, so_oe, wip, commit_p, wren_p, wrdi_p, wrsr_p;
   logic [7:0] wrsr_d;

   always #2.5 clk = ~clk;

   spi_eeprom_engine #(.ADDR_W(12), .PAGE_W(5), .T_WR(TW), .SYNC_STAGES(2)) u_dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .sck         (sck),
      .cs_n        (cs_n),
      .si          (si),
      .so          (so),
      .so_oe       (so_oe),
      .wel_i       (wel),
      .bp_i        (bp),
      .stat_i      (stat),
      .wip_o       (wip),
      .commit_o    (commit_p),
      .wren_o      (wren_p),
      .wrdi_o      (wrdi_p),
      .wrsr_o      (wrsr_p),
      .wrsr_data_o (wrsr_d)
   );

   int n_vec = 0, n_bad = 0;
   int n_commit = 0, n_wren = 0, n_wrdi = 0, n_wrsr = 0;
   logic [7:0] last_wrsr = 8'h00;
   bit m3 = 1'b0;
   bit oe_seen = 1'b0;
   logic oe_mid = 1'b0;
   logic [7:0] wbuf [64];
   logic [7:0] rbuf [64];

   always @(posedge clk) begin
      if (commit_p) n_commit++;
      if (wren_p) n_wren++;
      if (wrdi_p) n_wrdi++;
      if (wrsr_p) begin
         n_wrsr++;
         last_wrsr = wrsr_d;
      end
   end

   always @(negedge clk) if (so_oe) oe_seen = 1'b1;

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic sel();
      sck = m3;
      tick(4);
      cs_n = 1'b0;
      tick(HALF);
   endtask

   task automatic desel();
      if (!m3) sck = 1'b0;
      tick(HALF);
      cs_n = 1'b1;
      tick(2);
   endtask

   task automatic bits(input logic [7:0] v, input int n, output logic [7:0] r);
      r = 8'h00;
      for (int i = 0; i < n; i++) begin
         sck = 1'b0;
         si = v[7-i];
         tick(HALF);
         r = {r[6:0], so};
         sck = 1'b1;
         tick(HALF);
      end
   endtask

   task automatic bytex(input logic [7:0] v);
      logic [7:0] r;
      bits(v, 8, r);
   endtask

   task automatic ee_write(input logic [15:0] a, input int n);
      sel();
      bytex(8'h02);
      bytex(a[15:8]);
      bytex(a[7:0]);
      for (int i = 0; i < n; i++) bytex(wbuf[i]);
      desel();
   endtask

   task automatic ee_read(input logic [15:0] a, input int n);
      logic [7:0] r;
      sel();
      bytex(8'h03);
      bytex(a[15:8]);
      bytex(a[7:0]);
      for (int i = 0; i < n; i++) begin
         bits(8'h00, 8, r);
         rbuf[i] = r;
         if (i == 0) oe_mid = so_oe;
      end
      desel();
   endtask

   task automatic wait_write(output int hi);
      hi = 0;
      for (int i = 0; i < TW + 200; i++) begin
         tick(1);
         if (wip) hi++;
         else if (hi > 0) break;
      end
   endtask

   task automatic wait_idle();
      for (int i = 0; i < TW + 200; i++) begin
         if (!wip) break;
         tick(1);
      end
      tick(4);
   endtask

   task automatic t_reset();
      check("R2", "so_oe after reset", so_oe, 0);
      check("R5", "wip after reset", wip, 0);
      check("R5", "no commit after reset", n_commit, 0);
   endtask

   task automatic t_write_read();
      int c0, hi;
      wel = 1'b1;
      wbuf[0] = 8'h3C; wbuf[1] = 8'h5A; wbuf[2] = 8'hC3;
      c0 = n_commit;
      ee_write(16'h0123, 3);
      wait_write(hi);
      check("R5", "one commit", n_commit - c0, 1);
      check("R5", "busy length", hi, TW);
      ee_read(16'hF123, 3);
      check("R3", "byte0 (top bits ignored)", rbuf[0], 8'h3C);
      check("R3", "byte1", rbuf[1], 8'h5A);
      check("R3", "byte2", rbuf[2], 8'hC3);
      check("R3", "so_oe during data", oe_mid, 1);
      check("R2", "so_oe after deselect", so_oe, 0);
   endtask

   task automatic t_mode3();
      m3 = 1'b1;
      ee_read(16'h0124, 2);
      check("R1", "mode 3 byte0", rbuf[0], 8'h5A);
      check("R1", "mode 3 byte1", rbuf[1], 8'hC3);
      m3 = 1'b0;
      sck = 1'b0;
      tick(4);
   endtask

   task automatic t_read_wrap();
      int hi;
      wbuf[0] = 8'hA1; wbuf[1] = 8'hA2;
      ee_write(16'h0FFE, 2);
      wait_write(hi);
      wbuf[0] = 8'hB0;
      ee_write(16'h0000, 1);
      wait_write(hi);
      ee_read(16'h0FFE, 3);
      check("R4", "0x0FFE", rbuf[0], 8'hA1);
      check("R4", "0x0FFF", rbuf[1], 8'hA2);
      check("R4", "wrap to 0x0000", rbuf[2], 8'hB0);
   endtask

   task automatic t_page_wrap();
      int hi, c0;
      for (int k = 0; k < 34; k++) wbuf[k] = 8'(k);
      c0 = n_commit;
      ee_write(16'h005E, 34);
      wait_write(hi);
      check("R6", "single commit", n_commit - c0, 1);
      ee_read(16'h0040, 1);
      check("R6", "page start overwritten", rbuf[0], 8'h02);
      ee_read(16'h005E, 2);
      check("R6", "offset 30 overwritten", rbuf[0], 8'h20);
      check("R6", "offset 31 overwritten", rbuf[1], 8'h21);
   endtask

   task automatic t_abort();
      int c0;
      logic [7:0] r;
      c0 = n_commit;
      sel(); bytex(8'h02); bytex(8'h01); bytex(8'h23); bits(8'hFF, 4, r); desel();
      tick(40);
      check("R7", "partial byte no commit", n_commit - c0, 0);
      sel(); bytex(8'h02); bytex(8'h01); bytex(8'h23); desel();
      tick(40);
      check("R7", "address only no commit", n_commit - c0, 0);
      sel(); bytex(8'h02); bytex(8'h01); bytex(8'h23); bytex(8'h66); bits(8'hFF, 3, r); desel();
      tick(40);
      check("R7", "byte plus bits no commit", n_commit - c0, 0);
      ee_read(16'h0123, 1);
      check("R7", "array unchanged", rbuf[0], 8'h3C);
   endtask

   task automatic t_wel();
      int c0;
      c0 = n_commit;
      wel = 1'b0;
      wbuf[0] = 8'h99;
      ee_write(16'h0123, 1);
      tick(40);
      check("R8", "no commit without wel", n_commit - c0, 0);
      wel = 1'b1;
      ee_read(16'h0123, 1);
      check("R8", "array unchanged", rbuf[0], 8'h3C);
   endtask

   task automatic t_busy();
      int c0;
      c0 = n_commit;
      wbuf[0] = 8'h11; wbuf[1] = 8'h22;
      ee_write(16'h0200, 2);
      tick(2);
      check("R9", "busy started", wip, 1);
      oe_seen = 1'b0;
      ee_read(16'h0200, 1);
      check("R9", "no output during busy read", oe_seen, 0);
      wbuf[0] = 8'h77;
      ee_write(16'h0201, 1);
      check("R9", "still busy", wip, 1);
      wait_idle();
      check("R9", "only first write committed", n_commit - c0, 1);
      ee_read(16'h0200, 2);
      check("R9", "0x200", rbuf[0], 8'h11);
      check("R9", "0x201 kept", rbuf[1], 8'h22);
   endtask

   task automatic t_protect();
      int c0, hi;
      c0 = n_commit;
      bp = 2'b01;
      wbuf[0] = 8'hEE;
      ee_write(16'h0C10, 1);
      tick(40);
      check("R10", "top quarter locked", n_commit - c0, 0);
      wbuf[0] = 8'hD4;
      ee_write(16'h0BF0, 1);
      wait_write(hi);
      check("R10", "below quarter writable", n_commit - c0, 1);
      ee_read(16'h0BF0, 1);
      check("R10", "stored below quarter", rbuf[0], 8'hD4);
      bp = 2'b10;
      wbuf[0] = 8'h12;
      ee_write(16'h0810, 1);
      tick(40);
      check("R10", "top half locked", n_commit - c0, 1);
      bp = 2'b11;
      wbuf[0] = 8'h55;
      ee_write(16'h0000, 1);
      tick(40);
      check("R10", "all locked", n_commit - c0, 1);
      bp = 2'b00;
      ee_read(16'h0000, 1);
      check("R10", "locked data unchanged", rbuf[0], 8'hB0);
   endtask

   task automatic t_rdsr();
      logic [7:0] r1, r2;
      stat = 8'hA5;
      sel();
      bytex(8'h05);
      bits(8'h00, 8, r1);
      bits(8'h00, 8, r2);
      desel();
      check("R11", "status byte 1", r1, 8'hA5);
      check("R11", "status byte 2", r2, 8'hA5);
   endtask

   task automatic t_cmds();
      int e0, d0, s0;
      logic [7:0] r;
      e0 = n_wren; d0 = n_wrdi; s0 = n_wrsr;
      sel(); bytex(8'h06); desel(); tick(8);
      check("R12", "write enable pulse", n_wren - e0, 1);
      sel(); bytex(8'h04); desel(); tick(8);
      check("R12", "write disable pulse", n_wrdi - d0, 1);
      sel(); bytex(8'h06); bits(8'hFF, 3, r); desel(); tick(8);
      check("R12", "enable with extra bits", n_wren - e0, 1);
      sel(); bytex(8'h01); bytex(8'h8C); desel(); tick(8);
      check("R12", "status write pulse", n_wrsr - s0, 1);
      check("R12", "status write data", last_wrsr, 8'h8C);
      sel(); bytex(8'h01); bits(8'h40, 5, r); desel(); tick(8);
      check("R12", "partial status write", n_wrsr - s0, 1);
   endtask

   task automatic t_unknown();
      int tot0;
      tot0 = n_wren + n_wrdi + n_wrsr + n_commit;
      oe_seen = 1'b0;
      sel(); bytex(8'h07); bytex(8'hAA); bytex(8'h55); desel(); tick(8);
      check("R13", "no event", n_wren + n_wrdi + n_wrsr + n_commit - tot0, 0);
      check("R13", "no output", oe_seen, 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_vec++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      tick(10);
      rst_n = 1'b1;
      tick(10);
      t_reset();
      t_write_read();
      t_mode3();
      t_read_wrap();
      t_page_wrap();
      t_abort();
      t_wel();
      t_busy();
      t_protect();
      t_rdsr();
      t_cmds();
      t_unknown();
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule